// File: doc/BRIEF.md
# Gated Singles and Coincidence Counter

This block watches four digital pulse lines, sampled once per clock, and counts activity on them over an integration window of programmable length. For each line it counts rising edges. For four fixed cross-pairs of lines it counts coincidences. A coincidence is level-based: a pair coincides in any sample where both of its lines are high, even when the two leading edges fell in different samples. The effective coincidence window is therefore the sum of the two pulse widths. Each overlap interval counts as one coincidence.

The window length is set in whole milliseconds, from 1 to 65535, and is timed by an external millisecond tick. When the window closes, all eight totals are copied in one cycle into a result bank, which is offered on a valid/ready output. The accumulators restart from zero in the same cycle, so counting continues with no gap. The result stream has no back-pressure on counting: windows keep closing whether or not the consumer takes the results. `res_valid` stays high with the bank stable until `res_ready` is sampled high. If a newer window closes before that handshake, the newer totals replace the bank and `overrun` is raised.

Top module: `gated_coinc_counter`

## Requirements
- R1: Lane i of `res_singles`, at bits [i*CNT_W +: CNT_W] for i = 0..3, holds the number of samples in which `pulse_in[i]` was 1 after being 0 in the previous sample. A line held high adds nothing further.
- R2: Lane k of `res_pairs`, at bits [k*CNT_W +: CNT_W], covers these input pairs: k=0 is inputs 0&2, k=1 is 0&3, k=2 is 1&2, k=3 is 1&3. The lane counts one coincidence on each sample where both inputs of its pair are high and they were not both high in the previous sample. This holds even when the two edges fall in different samples.
- R3: Once counting is enabled, a window closes on the `win_len`-th `ms_tick` sample. On that edge the bank is loaded and `res_valid` is 1 from the next cycle. No window closes on any earlier tick.
- R4: An event sampled in the cycle a window closes belongs to the closing window. Events in the following cycle are counted into the new window, which starts from zero.
- R5: Every accumulator saturates at all-ones and does not wrap.
- R6: While `res_valid` is 1 and `res_ready` is 0, `res_valid` and both banks hold, unless a new window closes.
- R7: A window that closes while `res_valid` is 1 and `res_ready` is 0 overwrites the bank with the newest totals and sets `overrun`. A handshake (`res_valid` and `res_ready` both 1) with no window closing in the same cycle clears `res_valid` and `overrun`.
- R8: While `run` is 0 or `win_len` is 0, nothing is counted, no window closes and the accumulators and millisecond count are cleared. A later enable starts a fresh window from zero.
- R9: After reset, `res_valid` and `overrun` are 0 and both banks are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pulse_in | input | 4 | Synchronized pulse lines, one sample per clock |
| ms_tick | input | 1 | One-cycle millisecond tick |
| win_len | input | WIN_W | Window length in ticks; 0 disables counting |
| run | input | 1 | 1 enables counting |
| res_valid | output | 1 | Result bank holds unconsumed totals |
| res_ready | input | 1 | Consumer accepts the bank |
| res_singles | output | 4*CNT_W | Per-line edge totals, lane i = line i |
| res_pairs | output | 4*CNT_W | Pair coincidence totals, lane order per R2 |
| overrun | output | 1 | An unconsumed bank was overwritten |

## Verification
The counting function is driven through a set of 16-sample patterns. One pattern has no activity, and one has single-sample pulses with single-sample gaps to show edges are counted rather than high samples. Others have staggered overlapping pulses that must give one coincidence for a pair whose edges differ, disjoint pulses on a counted pair that must give no coincidence, and all lines held high that must give one of everything. A mixed phase pattern checks that every pair lane is mapped to the right inputs. Directed sequences then test a multi-tick window, an edge placed in the closing cycle against one placed just after it, an ignored handshake followed by an overwrite, saturation, and disable by `run` or a zero length.

// File: rtl/gcc_pkg.sv
package gcc_pkg;
  localparam int NCH   = 4;
  localparam int NPAIR = 4;

  // first input of coincidence pair p
  function automatic int pair_a(input int p);
    return (p < 2) ? 0 : 1;
  endfunction

  // second input of coincidence pair p
  function automatic int pair_b(input int p);
    return (p % 2 == 0) ? 2 : 3;
  endfunction
endpackage

// File: rtl/gcc_edge_detect.sv
module gcc_edge_detect
  import gcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   smp,
  output logic [NCH-1:0]   ch_rise,
  output logic [NPAIR-1:0] pair_rise
);
  logic [NCH-1:0]   prev_q;
  logic [NPAIR-1:0] and_now;
  logic [NPAIR-1:0] and_prev_q;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign and_now[p] = smp[pair_a(p)] & smp[pair_b(p)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q     <= '0;
      and_prev_q <= '0;
    end else begin
      prev_q     <= smp;
      and_prev_q <= and_now;
    end
  end

  assign ch_rise   = smp & ~prev_q;
  assign pair_rise = and_now & ~and_prev_q;

  // R2
  pair_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_rise[0] |=> !pair_rise[0]);
endmodule

// File: rtl/gcc_sat_counter.sv
module gcc_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         roll,
  input  logic         inc,
  output logic [W-1:0] cnt_nxt
);
  localparam logic [W-1:0] TOP = '1;
  logic [W-1:0] cnt_q;

  assign cnt_nxt = (inc && cnt_q != TOP) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr || roll) cnt_q <= '0;
    else                  cnt_q <= cnt_nxt;
  end

  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == TOP && !clr && !roll) |=> cnt_q == TOP);

  // R1
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !roll) |=> (cnt_q - $past(cnt_q)) <= 1);
endmodule

// File: rtl/gcc_window_timer.sv
module gcc_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WIN_W-1:0] win_len,
  input  logic             ms_tick,
  output logic             active,
  output logic             win_end
);
  logic [WIN_W-1:0] ms_cnt;
  logic             last_ms;

  assign active  = run && (win_len != '0);
  assign last_ms = ({1'b0, ms_cnt} + 1'b1) >= {1'b0, win_len};
  assign win_end = active && ms_tick && last_ms;

  always_ff @(posedge clk) begin
    if (!rst_n)       ms_cnt <= '0;
    else if (!active) ms_cnt <= '0;
    else if (ms_tick) ms_cnt <= win_end ? '0 : ms_cnt + 1'b1;
  end

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ms_cnt == '0);
endmodule

// File: rtl/gated_coinc_counter.sv
module gated_coinc_counter
  import gcc_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int WIN_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         pulse_in,
  input  logic                   ms_tick,
  input  logic [WIN_W-1:0]       win_len,
  input  logic                   run,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [NCH*CNT_W-1:0]   res_singles,
  output logic [NPAIR*CNT_W-1:0] res_pairs,
  output logic                   overrun
);
  logic                   active, win_end;
  logic [NCH-1:0]         ch_rise;
  logic [NPAIR-1:0]       pair_rise;
  logic [NCH*CNT_W-1:0]   s_nxt;
  logic [NPAIR*CNT_W-1:0] p_nxt;

  gcc_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .smp(pulse_in),
    .ch_rise(ch_rise), .pair_rise(pair_rise)
  );

  gcc_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .win_len(win_len),
    .ms_tick(ms_tick), .active(active), .win_end(win_end)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_single
    gcc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(!active), .roll(win_end),
      .inc(active && ch_rise[i]), .cnt_nxt(s_nxt[i*CNT_W +: CNT_W])
    );
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    gcc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(!active), .roll(win_end),
      .inc(active && pair_rise[k]), .cnt_nxt(p_nxt[k*CNT_W +: CNT_W])
    );
  end

  logic take;
  assign take = res_valid && res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_singles <= '0;
      res_pairs   <= '0;
      res_valid   <= 1'b0;
      overrun     <= 1'b0;
    end else if (win_end) begin
      res_singles <= s_nxt;
      res_pairs   <= p_nxt;
      res_valid   <= 1'b1;
      overrun     <= res_valid && !res_ready;
    end else if (take) begin
      res_valid   <= 1'b0;
      overrun     <= 1'b0;
    end
  end

  // R6
  hold_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !win_end) |=>
      (res_valid && $stable(res_singles) && $stable(res_pairs)));

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && res_valid && !res_ready) |=> overrun);

  // R3
  valid_from_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(win_end));

  // R8
  idle_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!run || win_len == '0) && !res_valid) |=> !res_valid);
endmodule

// File: tb/gated_coinc_counter_tb_top.sv
module gated_coinc_counter_tb_top;
  localparam int CW = 8;
  localparam int WW = 16;
  localparam int NV = 6;
  // per vector: channel c, step s at bit c*16+s
  localparam logic [63:0] VEC [NV] = '{
    64'h0000_0000_0000_0000,
    64'h0000_0000_0000_5555,
    64'h0000_0FF0_0000_00FF,
    64'hF0F0_0000_0F0F_0000,
    64'hFFFF_FFFF_FFFF_FFFF,
    64'h0F0F_AAAA_6666_3333
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] pulse_in = '0;
  logic ms_tick = 1'b0;
  logic [WW-1:0] win_len = '0;
  logic run = 1'b0;
  logic res_ready = 1'b0;
  logic res_valid, overrun;
  logic [4*CW-1:0] res_singles, res_pairs;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gated_coinc_counter #(.CNT_W(CW), .WIN_W(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .ms_tick(ms_tick),
    .win_len(win_len), .run(run), .res_valid(res_valid),
    .res_ready(res_ready), .res_singles(res_singles),
    .res_pairs(res_pairs), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] p, input logic t);
    pulse_in = p;
    ms_tick  = t;
    @(posedge clk);
    @(negedge clk);
    ms_tick  = 1'b0;
  endtask

  function automatic int rises(input logic [15:0] b);
    int n = 0;
    logic pv = 1'b0;
    for (int s = 0; s < 16; s++) begin
      if (b[s] && !pv) n++;
      pv = b[s];
    end
    return n;
  endfunction

  function automatic int sl(input int i);
    return int'(res_singles[i*CW +: CW]);
  endfunction

  function automatic int pl(input int k);
    return int'(res_pairs[k*CW +: CW]);
  endfunction

  task automatic quiet();
    run = 1'b0; res_ready = 1'b1;
    cyc(4'h0, 1'b0);
    cyc(4'h0, 1'b0);
    res_ready = 1'b0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 valid", res_valid, 0);
    chk("R9 overrun", overrun, 0);
    chk("R9 singles", (res_singles == '0), 1);
    chk("R9 pairs", (res_pairs == '0), 1);

    // table of patterns, one-tick windows
    for (int v = 0; v < NV; v++) begin
      logic [15:0] ch [4];
      quiet();
      for (int c = 0; c < 4; c++) ch[c] = VEC[v][c*16 +: 16];
      win_len = 16'd1; run = 1'b1;
      for (int s = 0; s < 16; s++)
        cyc({ch[3][s], ch[2][s], ch[1][s], ch[0][s]}, 1'b0);
      chk("R3 no early close", res_valid, 0);
      cyc(4'h0, 1'b1);
      chk("R3 valid after tick", res_valid, 1);
      for (int c = 0; c < 4; c++) chk("R1 singles", sl(c), rises(ch[c]));
      chk("R2 pair0 in0&in2", pl(0), rises(ch[0] & ch[2]));
      chk("R2 pair1 in0&in3", pl(1), rises(ch[0] & ch[3]));
      chk("R2 pair2 in1&in2", pl(2), rises(ch[1] & ch[2]));
      chk("R2 pair3 in1&in3", pl(3), rises(ch[1] & ch[3]));
      res_ready = 1'b1;
      cyc(4'h0, 1'b0);
      res_ready = 1'b0;
      chk("R6 handshake clears valid", res_valid, 0);
    end

    // R8: zero length and run low ignore activity
    quiet();
    win_len = 16'd0; run = 1'b1;
    for (int n = 0; n < 10; n++) cyc((n % 2 == 0) ? 4'hF : 4'h0, 1'b1);
    chk("R8 no window at len 0", res_valid, 0);
    win_len = 16'd1;
    cyc(4'h0, 1'b1);
    chk("R8 window after enable", res_valid, 1);
    chk("R8 nothing carried from len 0", sl(0), 0);
    chk("R8 no pair carried", pl(0), 0);

    // R3: three-tick window
    quiet();
    win_len = 16'd3; run = 1'b1;
    cyc(4'h1, 1'b1);
    cyc(4'h0, 1'b0);
    cyc(4'h0, 1'b1);
    chk("R3 open after two ticks", res_valid, 0);
    cyc(4'h1, 1'b1);
    chk("R3 close on third tick", res_valid, 1);
    chk("R3 ch0 edges", sl(0), 2);

    // R4: boundary attribution
    quiet();
    win_len = 16'd1; run = 1'b1;
    cyc(4'h1, 1'b1);
    chk("R4 edge in closing cycle", sl(0), 1);
    res_ready = 1'b1;
    cyc(4'h3, 1'b0);
    res_ready = 1'b0;
    cyc(4'h0, 1'b1);
    chk("R4 new window ch0", sl(0), 0);
    chk("R4 new window ch1", sl(1), 1);

    // R6 hold then R7 overwrite
    for (int n = 0; n < 3; n++) cyc(4'h0, 1'b0);
    chk("R6 valid held", res_valid, 1);
    chk("R6 bank held", sl(1), 1);
    cyc(4'h4, 1'b1);
    chk("R7 overrun set", overrun, 1);
    chk("R7 newest ch2", sl(2), 1);
    chk("R7 newest ch1", sl(1), 0);
    res_ready = 1'b1;
    cyc(4'h0, 1'b0);
    res_ready = 1'b0;
    chk("R7 overrun cleared", overrun, 0);
    chk("R7 valid cleared", res_valid, 0);

    // R5: saturation
    quiet();
    win_len = 16'd1; run = 1'b1;
    for (int n = 0; n < 300; n++) begin
      cyc(4'h8, 1'b0);
      cyc(4'h0, 1'b0);
    end
    cyc(4'h0, 1'b1);
    chk("R5 saturated ch3", sl(3), 255);
    chk("R5 ch0 untouched", sl(0), 0);

    // R8: stop mid-window restarts from zero
    quiet();
    win_len = 16'd2; run = 1'b1;
    cyc(4'h1, 1'b1);
    run = 1'b0;
    cyc(4'h0, 1'b0);
    run = 1'b1;
    cyc(4'h0, 1'b1);
    chk("R8 restart needs full window", res_valid, 0);
    cyc(4'h0, 1'b1);
    chk("R8 restart closes", res_valid, 1);
    chk("R8 pre-stop edge dropped", sl(0), 0);

    done = 1;
    finish_up();
  end
endmodule